// File: doc/BRIEF.md
# Indexed Channel Timing Register Window

This block gives a host a byte-wide, two-port window onto the internal registers of one disk channel. The host first writes a register number into the index port. It then reads or writes the selected register through the data port. The registers behind the window are:

- eight timing bytes for each attached drive;
- a system control byte whose bit 6 turns on a test mode;
- a status byte that reports the cable type seen on an input pin;
- four byte views of a free-running down-counter.

While test mode is on, the counter drops by one on every clock. Software uses this to measure the clock rate against its own timebase. The timing bytes do not drive any transfer logic inside this block. They leave the block as plain register outputs for the drive-side timing generator. The hold-time control bit of each drive is also brought out on its own pin.

Top module: `idxwin_port`

## Requirements
- R1: A write to port offset 1 loads the 8-bit index register. A read at offset 1 returns the index.
- R2: A write to offset 3 while the index is 0x0C+8·d+k (drive d of 0..1, slot k of 0..7) stores the byte in that timing register. The stored byte appears on `timing_regs[(d*8+k)*8 +: 8]` from the next clock edge.
- R3: A read at offset 3 while the index selects a timing register returns that register's stored value.
- R4: Index 0x0B reads as 0x04 when `cable_40w` is 1 (40-wire cable) and as 0x00 when it is 0 (80-wire cable). Writes to index 0x0B change nothing.
- R5: Index 0x01 is a full 8-bit read/write control register. A read-modify-write keeps every bit. `test_mode` equals its bit 6.
- R6: The counter is CNT_W bits wide (30 by default). It falls by one on each clock edge while `test_mode` is 1, holds while `test_mode` is 0, and wraps from zero to all ones.
- R7: Indices 0x20, 0x21, 0x22 and 0x23 read counter bits 7:0, 15:8, 23:16 and 31:24 respectively. Bits above CNT_W-1 read as zero, and writes to these indices are ignored.
- R8: Reads at an unimplemented index, or at a port offset other than 1 and 3, return 0x00. Writes to those places change no register.
- R9: After reset the index, control and timing registers are 0x00, the counter is all ones, and the read data is 0x00.
- R10: `hold_ctl[d]` is bit 7 of drive d's slot-4 timing register (index 0x10 for drive 0, 0x18 for drive 1).
- R11: Each read returns register state as it stood in the cycle where the read strobe was sampled. The value appears on `host_rdata` after that edge and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | ADDR_W | Byte offset within the port block |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| cable_40w | input | 1 | Cable-type input, 1 for a 40-wire cable |
| test_mode | output | 1 | Control bit 6; enables the counter |
| hold_ctl | output | N_DRIVES | Hold-time control bit of each drive |
| timing_regs | output | N_DRIVES·REGS·8 | All timing bytes, drive-major |

## Verification
Every result of this block is due exactly one clock edge after its cause:

- a write shows in storage and on the outputs after the edge that samples the strobe;
- a read shows on `host_rdata` after that same edge;
- the counter moves one step per edge, using the control value that stood before the edge.

The bench drives inputs on falling edges. Its reference model updates on rising edges in the same order: read old state, step the counter with the old control bit, then apply writes. All outputs are compared on the next falling edge, half a cycle after the result is due.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  localparam int unsigned BYTE_W = 8;

  // Pick one byte of a zero-extended counter value.
  function automatic logic [BYTE_W-1:0] cnt_byte(input logic [31:0] c, input logic [1:0] sel);
    case (sel)
      2'd0:    return c[7:0];
      2'd1:    return c[15:8];
      2'd2:    return c[23:16];
      default: return c[31:24];
    endcase
  endfunction

  // Status byte with the cable flag at its bit position.
  function automatic logic [BYTE_W-1:0] status_byte(input logic cable, input int unsigned bitpos);
    return BYTE_W'(cable) << bitpos;
  endfunction
endpackage

// File: rtl/idxwin_counter.sv
module idxwin_counter #(
  parameter int unsigned CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] count_q
);
  // Free-running down-counter; wraps modulo 2^CNT_W.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '1;
    else if (run) count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/idxwin_decode.sv
module idxwin_decode #(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned INDEX_PORT  = 1,
  parameter int unsigned DATA_PORT   = 3,
  parameter int unsigned N_DRIVES    = 2,
  parameter int unsigned REGS        = 8,
  parameter int unsigned TIMING_BASE = 8'h0C,
  parameter int unsigned STRIDE      = 8,
  parameter int unsigned CTRL_IDX    = 8'h01,
  parameter int unsigned STAT_IDX    = 8'h0B,
  parameter int unsigned CNT_IDX     = 8'h20,
  localparam int unsigned DRV_W      = (N_DRIVES > 1) ? $clog2(N_DRIVES) : 1,
  localparam int unsigned SLOT_W     = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        index_q,
  output logic              at_index,
  output logic              at_data,
  output logic              sel_ctrl,
  output logic              sel_stat,
  output logic              sel_cnt,
  output logic              sel_tim,
  output logic [DRV_W-1:0]  tim_drive,
  output logic [SLOT_W-1:0] tim_slot
);
  assign at_index = (host_addr == ADDR_W'(INDEX_PORT));
  assign at_data  = (host_addr == ADDR_W'(DATA_PORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   index_q <= '0;
    else if (host_wr && at_index) index_q <= host_wdata;
  end

  assign sel_ctrl = (index_q == 8'(CTRL_IDX));
  assign sel_stat = (index_q == 8'(STAT_IDX));
  assign sel_cnt  = (index_q[7:2] == 6'(CNT_IDX >> 2));

  // Timing window: drive-major blocks of STRIDE indices, REGS used in each.
  always_comb begin
    int off;
    off       = int'(index_q) - int'(TIMING_BASE);
    sel_tim   = (off >= 0) && (off < int'(N_DRIVES * STRIDE)) && ((off % int'(STRIDE)) < int'(REGS));
    tim_drive = DRV_W'(off / int'(STRIDE));
    tim_slot  = SLOT_W'(off % int'(STRIDE));
  end
endmodule

// File: rtl/idxwin_regs.sv
module idxwin_regs #(
  parameter int unsigned N_DRIVES = 2,
  parameter int unsigned REGS     = 8,
  localparam int unsigned DRV_W   = (N_DRIVES > 1) ? $clog2(N_DRIVES) : 1,
  localparam int unsigned SLOT_W  = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_we,
  input  logic                      tim_we,
  input  logic [DRV_W-1:0]          tim_drive,
  input  logic [SLOT_W-1:0]         tim_slot,
  input  logic [7:0]                wdata,
  output logic [7:0]                ctrl_q,
  output logic [N_DRIVES*REGS*8-1:0] tim_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata;
  end

  for (genvar d = 0; d < N_DRIVES; d++) begin : g_drv
    for (genvar s = 0; s < REGS; s++) begin : g_slot
      logic [7:0] r_q;
      logic       hit;
      assign hit = tim_we && (tim_drive == DRV_W'(d)) && (tim_slot == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   r_q <= '0;
        else if (hit) r_q <= wdata;
      end
      assign tim_flat[(d*REGS+s)*8 +: 8] = r_q;
    end
  end
endmodule

// File: rtl/idxwin_port.sv
module idxwin_port
  import idxwin_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned INDEX_PORT  = 1,
  parameter int unsigned DATA_PORT   = 3,
  parameter int unsigned N_DRIVES    = 2,
  parameter int unsigned REGS        = 8,
  parameter int unsigned TIMING_BASE = 8'h0C,
  parameter int unsigned STRIDE      = 8,
  parameter int unsigned CTRL_IDX    = 8'h01,
  parameter int unsigned STAT_IDX    = 8'h0B,
  parameter int unsigned CNT_IDX     = 8'h20,
  parameter int unsigned TEST_BIT    = 6,
  parameter int unsigned CABLE_BIT   = 2,
  parameter int unsigned HOLD_SLOT   = 4,
  parameter int unsigned CNT_W       = 30,
  localparam int unsigned DRV_W      = (N_DRIVES > 1) ? $clog2(N_DRIVES) : 1,
  localparam int unsigned SLOT_W     = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int unsigned TIM_W      = N_DRIVES * REGS * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  input  logic                cable_40w,
  output logic                test_mode,
  output logic [N_DRIVES-1:0] hold_ctl,
  output logic [TIM_W-1:0]    timing_regs
);
  logic [7:0]        index_q;
  logic              at_index, at_data;
  logic              sel_ctrl, sel_stat, sel_cnt, sel_tim;
  logic [DRV_W-1:0]  tim_drive;
  logic [SLOT_W-1:0] tim_slot;
  logic [7:0]        ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_tick;
  logic              ctrl_we, tim_we;
  logic [7:0]        rd_val;

  idxwin_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
    .N_DRIVES(N_DRIVES), .REGS(REGS), .TIMING_BASE(TIMING_BASE), .STRIDE(STRIDE),
    .CTRL_IDX(CTRL_IDX), .STAT_IDX(STAT_IDX), .CNT_IDX(CNT_IDX)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .index_q(index_q), .at_index(at_index),
    .at_data(at_data), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
    .sel_cnt(sel_cnt), .sel_tim(sel_tim), .tim_drive(tim_drive), .tim_slot(tim_slot)
  );

  assign ctrl_we = host_wr && at_data && sel_ctrl;
  assign tim_we  = host_wr && at_data && sel_tim;

  idxwin_regs #(.N_DRIVES(N_DRIVES), .REGS(REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .tim_we(tim_we),
    .tim_drive(tim_drive), .tim_slot(tim_slot), .wdata(host_wdata),
    .ctrl_q(ctrl_q), .tim_flat(timing_regs)
  );

  assign test_mode = ctrl_q[TEST_BIT];
  assign cnt_tick  = test_mode;

  idxwin_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cnt_tick), .count_q(cnt_q)
  );

  for (genvar d = 0; d < N_DRIVES; d++) begin : g_hold
    assign hold_ctl[d] = timing_regs[(d*REGS+HOLD_SLOT)*8 + 7];
  end

  always_comb begin
    rd_val = '0;
    if (at_index) rd_val = index_q;
    else if (at_data) begin
      if (sel_ctrl)     rd_val = ctrl_q;
      else if (sel_stat) rd_val = status_byte(cable_40w, CABLE_BIT);
      else if (sel_tim)  rd_val = timing_regs[(int'(tim_drive)*int'(REGS) + int'(tim_slot))*8 +: 8];
      else if (sel_cnt)  rd_val = cnt_byte(32'(cnt_q), index_q[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_val;
  end
endmodule

// File: rtl/idxwin_checker.sv
module idxwin_checker #(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned INDEX_PORT = 1,
  parameter int unsigned DATA_PORT  = 3,
  parameter int unsigned CTRL_IDX   = 8'h01,
  parameter int unsigned STAT_IDX   = 8'h0B,
  parameter int unsigned TEST_BIT   = 6,
  parameter int unsigned CABLE_BIT  = 2,
  parameter int unsigned CNT_W      = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              cable_40w,
  input logic              test_mode,
  input logic [7:0]        index_q,
  input logic [CNT_W-1:0]  cnt_q
);
  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(INDEX_PORT)) |=> index_q == $past(host_wdata));

  p_index_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(INDEX_PORT)) |=> host_rdata == $past(index_q));

  p_cable_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(DATA_PORT) && index_q == 8'(STAT_IDX))
      |=> host_rdata == ($past(cable_40w) ? (8'd1 << CABLE_BIT) : 8'd0));

  p_mode_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(DATA_PORT) && index_q == 8'(CTRL_IDX))
      |=> test_mode == $past(host_wdata[TEST_BIT]));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> $stable(cnt_q));

  p_offset_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != ADDR_W'(INDEX_PORT) && host_addr != ADDR_W'(DATA_PORT))
      |=> host_rdata == 8'h00);

  p_reset_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&cnt_q));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

bind idxwin_port idxwin_checker #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
  .CTRL_IDX(CTRL_IDX), .STAT_IDX(STAT_IDX), .TEST_BIT(TEST_BIT),
  .CABLE_BIT(CABLE_BIT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .cable_40w(cable_40w), .test_mode(test_mode), .index_q(index_q), .cnt_q(cnt_q)
);

// File: tb/idxwin_port_test.sv
`timescale 1ns/1ps
module idxwin_port_test;
  localparam int CW   = 12;
  localparam int MASK = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wd = 8'd0;
  logic       cable = 1'b0;
  wire  [7:0]   rdata;
  wire          tm;
  wire  [1:0]   hold;
  wire  [127:0] tim;

  always #4 clk = ~clk;

  idxwin_port #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(wr), .host_rd(rd), .host_addr(addr),
    .host_wdata(wd), .host_rdata(rdata), .cable_40w(cable), .test_mode(tm),
    .hold_ctl(hold), .timing_regs(tim)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Behavioural reference model
  int    m_idx, m_ctrl, m_cnt;
  int    m_tim [16];
  int    m_rdata;
  string m_tag = "R9";

  function automatic int m_read(int a);
    if (a == 1) return m_idx;
    if (a != 3) return 0;
    if (m_idx == 1) return m_ctrl;
    if (m_idx == 8'h0B) return cable ? 4 : 0;
    if (m_idx >= 8'h0C && m_idx <= 8'h1B) return m_tim[m_idx - 8'h0C];
    if (m_idx >= 8'h20 && m_idx <= 8'h23) return (m_cnt >> (8 * (m_idx - 8'h20))) & 255;
    return 0;
  endfunction

  function automatic string m_tagof(int a);
    if (a == 1) return "R1";
    if (a != 3) return "R8";
    if (m_idx == 1) return "R5";
    if (m_idx == 8'h0B) return "R4";
    if (m_idx >= 8'h0C && m_idx <= 8'h1B) return "R3";
    if (m_idx >= 8'h20 && m_idx <= 8'h23) return "R7";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_ctrl = 0; m_cnt = MASK; m_rdata = 0; m_tag = "R9";
      foreach (m_tim[i]) m_tim[i] = 0;
    end else begin
      int run;
      run = (m_ctrl >> 6) & 1;
      if (rd) begin m_rdata = m_read(int'(addr)); m_tag = m_tagof(int'(addr)); end
      if (run != 0) m_cnt = (m_cnt - 1) & MASK;
      if (wr) begin
        if (addr == 3'd1) m_idx = int'(wd);
        else if (addr == 3'd3) begin
          if (m_idx == 1) m_ctrl = int'(wd);
          else if (m_idx >= 8'h0C && m_idx <= 8'h1B) m_tim[m_idx - 8'h0C] = int'(wd);
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(rdata), m_rdata, {m_tag, " rdata R11"});
      chk(int'(tm), (m_ctrl >> 6) & 1, "R5 test_mode");
      for (int d = 0; d < 2; d++) chk(int'(hold[d]), (m_tim[d*8+4] >> 7) & 1, "R10 hold_ctl");
      for (int i = 0; i < 16; i++) chk(int'(tim[i*8 +: 8]), m_tim[i], "R2 timing_regs");
    end
  end

  task automatic op(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = w; rd = r; addr = a; wd = d;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input int exp, input string tag);
    op(1'b0, 1'b1, a, 8'h00);
    chk(int'(rdata), exp, tag);
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    op(1'b1, 1'b0, 3'd1, idx);
    op(1'b1, 1'b0, 3'd3, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk(int'(rdata), 0, "R9 rdata");
    chk(int'(tm), 0, "R9 test_mode");
    chk(int'(tim[31:0]), 0, "R9 timing");
    rd_exp(3'd1, 8'h00, "R9 index");
    op(1'b1, 1'b0, 3'd1, 8'h01); rd_exp(3'd3, 8'h00, "R9 control");
    op(1'b1, 1'b0, 3'd1, 8'h20); rd_exp(3'd3, 8'hFF, "R9 counter byte0");
    op(1'b1, 1'b0, 3'd1, 8'h21); rd_exp(3'd3, 8'h0F, "R9 counter byte1");
    // R1
    op(1'b1, 1'b0, 3'd1, 8'h5A); rd_exp(3'd1, 8'h5A, "R1 index readback");
    // R2 / R3 every timing slot of both drives
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 8; k++) begin
        v = 8'((k * 8'h13) ^ (d * 8'hA5) ^ 8'h3C);
        wr_reg(8'(8'h0C + 8*d + k), v);
        chk(int'(tim[(d*8+k)*8 +: 8]), int'(v), "R2 slot update");
        rd_exp(3'd3, int'(v), "R3 slot read");
      end
    // R10 hold bit: set, then read-modify-write clear on drive 0 and drive 1
    wr_reg(8'h10, 8'hC3); chk(int'(hold[0]), 1, "R10 hold set");
    rd_exp(3'd3, 8'hC3, "R10 read");
    op(1'b1, 1'b0, 3'd3, rdata & 8'h7F);
    chk(int'(hold[0]), 0, "R10 hold cleared");
    rd_exp(3'd3, 8'h43, "R10 other bits kept");
    wr_reg(8'h18, 8'h80); chk(int'(hold[1]), 1, "R10 drive1 hold");
    // R4 cable status
    cable = 1'b1;
    op(1'b1, 1'b0, 3'd1, 8'h0B); rd_exp(3'd3, 8'h04, "R4 40-wire");
    op(1'b1, 1'b0, 3'd3, 8'hFF); rd_exp(3'd3, 8'h04, "R4 write ignored");
    cable = 1'b0; rd_exp(3'd3, 8'h00, "R4 80-wire");
    // R5 control read-modify-write
    wr_reg(8'h01, 8'h25); rd_exp(3'd3, 8'h25, "R5 control read");
    chk(int'(tm), 0, "R5 mode off");
    op(1'b1, 1'b0, 3'd3, rdata | 8'h40);
    chk(int'(tm), 1, "R5 mode on");
    rd_exp(3'd3, 8'h65, "R5 bits preserved");
    repeat (20) @(negedge clk);
    // R6 hold while test mode off
    op(1'b1, 1'b0, 3'd3, 8'h25);
    op(1'b1, 1'b0, 3'd1, 8'h20); rd_exp(3'd3, m_cnt & 255, "R7 byte0");
    v = rdata;
    repeat (10) @(negedge clk);
    rd_exp(3'd3, int'(v), "R6 frozen");
    op(1'b1, 1'b0, 3'd3, 8'h00); rd_exp(3'd3, int'(v), "R7 write ignored");
    op(1'b1, 1'b0, 3'd1, 8'h23); rd_exp(3'd3, 0, "R7 bits above width");
    // R6 wrap: run past zero
    wr_reg(8'h01, 8'h40);
    repeat (4200) @(negedge clk);
    wr_reg(8'h01, 8'h00);
    op(1'b1, 1'b0, 3'd1, 8'h21); rd_exp(3'd3, (m_cnt >> 8) & 255, "R6 after wrap");
    // R8 unimplemented
    wr_reg(8'h1C, 8'hAB); rd_exp(3'd3, 0, "R8 index 0x1C");
    op(1'b1, 1'b0, 3'd1, 8'h40); rd_exp(3'd3, 0, "R8 index 0x40");
    op(1'b1, 1'b0, 3'd2, 8'h77); rd_exp(3'd2, 0, "R8 offset 2");
    rd_exp(3'd0, 0, "R8 offset 0");
    rd_exp(3'd1, 8'h40, "R8 offset write left index");
    op(1'b1, 1'b0, 3'd1, 8'h0C); rd_exp(3'd3, m_tim[0], "R8 timing untouched");
    // R11 rdata held without read
    repeat (3) @(negedge clk);
    chk(int'(rdata), m_tim[0], "R11 hold");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule